// File: doc/BRIEF.md
# Three-Wire Serial Command Slave

This block is the bus-facing engine of a peripheral reached over a three-wire serial link. The link has an enable line, a serial clock and one bidirectional data line. The host raises enable with the serial clock low and shifts in a command byte, least significant bit first, on rising clock edges. The command names a read or a write, one of two address spaces (clock registers or RAM), and a 5-bit address. The block then either collects one write byte, or drives read data back on falling clock edges. The all-ones address selects burst mode, which walks upward from address 0.

Toward the local register bank, the block issues single-cycle read and write strobes with a space select, an address and write data. Read data is returned by the bank one system clock after the read strobe. The three bus inputs are oversampled in the system clock domain. Each bus clock half-period must therefore last at least four system clocks. The data pin is released through an output-enable signal.

Top module: `tw3_slave`

## Requirements
- R1: A transfer starts only when the synchronized enable rises while the synchronized serial clock is low. If the serial clock is high at that moment, the whole transfer is ignored until enable falls: no strobe is issued and no data is driven.
- R2: When enable goes low, the transfer ends. The output enable drops, and no strobe appears, from SYNC_STAGES+3 system clocks after the low level is first sampled.
- R3: The first eight rising serial clock edges shift in the command byte, bit 0 first. Bit 0 set means read and clear means write. Bits 5:1 are the address. Bit 6 selects RAM (1, `reg_ram_o`=1) or clock space (0). Bit 7 is the write permission.
- R4: A write command whose bit 7 is 0 produces no `reg_wr_o` pulse.
- R5: In a single write, the eighth rising edge after the command produces one `reg_wr_o` pulse. The pulse carries the command's address and space, and the data byte assembled bit 0 first.
- R6: After a single write byte, further serial clocks are ignored while enable stays high.
- R7: A read command produces one `reg_rd_o` pulse. The returned byte is driven bit 0 first, one bit on each falling edge, starting with the first falling edge after the last command bit.
- R8: In a single read, further clocks retransmit the same byte from bit 0 for as long as enable stays high, with no new read strobe.
- R9: The output enable is high only during a read data phase. It is set on a falling serial clock edge and cleared on every rising edge.
- R10: Address 31 selects burst mode, which starts at address 0 and increments after each byte, for at most BURST_MAX (default 31) bytes. A burst write strobes every completed byte. Later clocks are ignored.
- R11: A burst read fetches the next byte during the last bit of the current one, so the bits continue without a gap. It issues BURST_MAX read strobes in total. After the last byte, the data pin stays released.
- R12: `reg_rd_o` and `reg_wr_o` are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tw_en_i | input | 1 | Bus enable line (asynchronous) |
| tw_sck_i | input | 1 | Bus serial clock (asynchronous) |
| tw_dat_i | input | 1 | Data line, input side |
| tw_dat_o | output | 1 | Data line, output value |
| tw_dat_oe_o | output | 1 | Data line output enable |
| reg_rd_o | output | 1 | Register bank read strobe |
| reg_wr_o | output | 1 | Register bank write strobe |
| reg_ram_o | output | 1 | Space select: 1 RAM, 0 clock registers |
| reg_addr_o | output | 5 | Register address |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, valid one clock after `reg_rd_o` |

## Verification
The hardest situation to reach is the end of a long burst read. There, the prefetch of the following byte and the byte-count limit act at nearly the same moment. The stimulus first fills all RAM locations with distinct values through a 32-byte burst write, of which the last byte must be dropped. It then clocks 32 bytes out of a burst read. Each bit is compared with the expected contents, and the pin must stay released through the whole extra byte.

// File: rtl/tw3_pkg.sv
package tw3_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ADDR_W = 5;
   localparam logic [ADDR_W-1:0] BURST_ADDR = '1;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CMD,
      PH_DATA,
      PH_HOLD
   } phase_e;

   // command byte, bit 7 down to bit 0
   typedef struct packed {
      logic              wr_ok;
      logic              ram_sel;
      logic [ADDR_W-1:0] addr;
      logic              rd;
   } cmd_t;
endpackage

// File: rtl/tw3_sync.sv
module tw3_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw3_ctrl.sv
module tw3_ctrl
   import tw3_pkg::*;
#(
   parameter int unsigned BURST_MAX = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_s,
   input  logic              sck_s,
   input  logic              dat_s,
   output logic              sck_rise_o,
   output logic              sck_fall_o,
   output logic              rd_o,
   output logic              rd_first_o,
   output logic              wr_o,
   output logic              ram_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              adv_o,
   output logic              rd_active_o,
   output logic [2:0]        bit_o
);
   localparam logic [ADDR_W-1:0] LAST_CNT = ADDR_W'(BURST_MAX - 1);

   phase_e            phase_q;
   logic [2:0]        bit_q;
   logic [BYTE_W-2:0] sh_q;
   cmd_t              cmd_q;
   logic              burst_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] cnt_q;
   logic              en_prev_q;
   logic              sck_prev_q;

   logic              en_rise;
   logic              last_bit;
   logic              last_byte;
   logic [BYTE_W-1:0] byte_w;
   cmd_t              cmd_w;
   logic              cmd_burst;

   assign en_rise    = en_s & ~en_prev_q;
   assign sck_rise_o = sck_s & ~sck_prev_q;
   assign sck_fall_o = ~sck_s & sck_prev_q;
   assign last_bit   = (bit_q == 3'd7);
   assign last_byte  = burst_q && (cnt_q == LAST_CNT);
   assign byte_w     = {dat_s, sh_q};
   assign cmd_w      = cmd_t'(byte_w);
   assign cmd_burst  = (cmd_w.addr == BURST_ADDR);

   assign rd_active_o = en_s && (phase_q == PH_DATA) && cmd_q.rd;
   assign bit_o       = bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         bit_q      <= '0;
         sh_q       <= '0;
         cmd_q      <= '0;
         burst_q    <= 1'b0;
         addr_q     <= '0;
         cnt_q      <= '0;
         en_prev_q  <= 1'b0;
         sck_prev_q <= 1'b0;
         rd_o       <= 1'b0;
         rd_first_o <= 1'b0;
         wr_o       <= 1'b0;
         ram_o      <= 1'b0;
         addr_o     <= '0;
         wdata_o    <= '0;
         adv_o      <= 1'b0;
      end else begin
         en_prev_q  <= en_s;
         sck_prev_q <= sck_s;
         rd_o       <= 1'b0;
         wr_o       <= 1'b0;
         adv_o      <= 1'b0;
         if (!en_s) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
         end else begin
            unique case (phase_q)
               PH_IDLE: begin
                  if (en_rise) begin
                     phase_q <= sck_s ? PH_HOLD : PH_CMD;
                     bit_q   <= '0;
                  end
               end
               PH_CMD: begin
                  if (sck_rise_o) begin
                     sh_q  <= {dat_s, sh_q[BYTE_W-2:1]};
                     bit_q <= bit_q + 3'd1;
                     if (last_bit) begin
                        cmd_q   <= cmd_w;
                        burst_q <= cmd_burst;
                        addr_q  <= cmd_burst ? '0 : cmd_w.addr;
                        cnt_q   <= '0;
                        phase_q <= PH_DATA;
                        if (cmd_w.rd) begin
                           rd_o       <= 1'b1;
                           rd_first_o <= 1'b1;
                           ram_o      <= cmd_w.ram_sel;
                           addr_o     <= cmd_burst ? '0 : cmd_w.addr;
                        end
                     end
                  end
               end
               PH_DATA: begin
                  if (sck_rise_o) begin
                     bit_q <= bit_q + 3'd1;
                     if (!cmd_q.rd) begin
                        sh_q <= {dat_s, sh_q[BYTE_W-2:1]};
                     end
                     // prefetch the following burst byte during the last bit
                     if (cmd_q.rd && burst_q && !last_byte && (bit_q == 3'd6)) begin
                        rd_o       <= 1'b1;
                        rd_first_o <= 1'b0;
                        ram_o      <= cmd_q.ram_sel;
                        addr_o     <= addr_q + 1'b1;
                     end
                     if (last_bit) begin
                        if (!cmd_q.rd && cmd_q.wr_ok) begin
                           wr_o    <= 1'b1;
                           ram_o   <= cmd_q.ram_sel;
                           addr_o  <= addr_q;
                           wdata_o <= byte_w;
                        end
                        if (burst_q) begin
                           addr_q <= addr_q + 1'b1;
                           cnt_q  <= cnt_q + 1'b1;
                           if (last_byte) begin
                              phase_q <= PH_HOLD;
                           end else if (cmd_q.rd) begin
                              adv_o <= 1'b1;
                           end
                        end else if (!cmd_q.rd) begin
                           phase_q <= PH_HOLD;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tw3_tx.sv
module tw3_tx
   import tw3_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] rdata_i,
   input  logic              rd_i,
   input  logic              rd_first_i,
   input  logic              adv_i,
   input  logic              active_i,
   input  logic              sck_rise_i,
   input  logic              sck_fall_i,
   input  logic [2:0]        bit_i,
   output logic              dat_o,
   output logic              oe_o
);
   logic              rd_d_q;
   logic              first_d_q;
   logic [BYTE_W-1:0] cur_q;
   logic [BYTE_W-1:0] nxt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_d_q    <= 1'b0;
         first_d_q <= 1'b0;
         cur_q     <= '0;
         nxt_q     <= '0;
         dat_o     <= 1'b0;
         oe_o      <= 1'b0;
      end else begin
         rd_d_q    <= rd_i;
         first_d_q <= rd_first_i;
         if (rd_d_q) begin
            if (first_d_q) cur_q <= rdata_i;
            else           nxt_q <= rdata_i;
         end
         if (adv_i) begin
            cur_q <= nxt_q;
         end
         if (!active_i || sck_rise_i) begin
            oe_o <= 1'b0;
         end else if (sck_fall_i) begin
            oe_o  <= 1'b1;
            dat_o <= cur_q[bit_i];
         end
      end
   end
endmodule

// File: rtl/tw3_slave.sv
module tw3_slave
   import tw3_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BURST_MAX   = 31
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tw_en_i,
   input  logic       tw_sck_i,
   input  logic       tw_dat_i,
   output logic       tw_dat_o,
   output logic       tw_dat_oe_o,
   output logic       reg_rd_o,
   output logic       reg_wr_o,
   output logic       reg_ram_o,
   output logic [4:0] reg_addr_o,
   output logic [7:0] reg_wdata_o,
   input  logic [7:0] reg_rdata_i
);
   localparam int unsigned LANES = 3;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw3_slave: SYNC_STAGES must be at least 2");
      end
      if ((BURST_MAX < 1) || (BURST_MAX > 31)) begin : g_bad_burst
         $error("tw3_slave: BURST_MAX must lie in 1..31");
      end
   endgenerate

   logic [LANES-1:0] lanes_s;
   logic             sck_rise;
   logic             sck_fall;
   logic             rd_first;
   logic             adv;
   logic             rd_active;
   logic [2:0]       bit_idx;

   tw3_sync #(.STAGES(SYNC_STAGES), .W(LANES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({tw_en_i, tw_sck_i, tw_dat_i}),
      .sync_o  (lanes_s)
   );

   tw3_ctrl #(.BURST_MAX(BURST_MAX)) ctrl_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_s        (lanes_s[2]),
      .sck_s       (lanes_s[1]),
      .dat_s       (lanes_s[0]),
      .sck_rise_o  (sck_rise),
      .sck_fall_o  (sck_fall),
      .rd_o        (reg_rd_o),
      .rd_first_o  (rd_first),
      .wr_o        (reg_wr_o),
      .ram_o       (reg_ram_o),
      .addr_o      (reg_addr_o),
      .wdata_o     (reg_wdata_o),
      .adv_o       (adv),
      .rd_active_o (rd_active),
      .bit_o       (bit_idx)
   );

   tw3_tx tx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rdata_i    (reg_rdata_i),
      .rd_i       (reg_rd_o),
      .rd_first_i (rd_first),
      .adv_i      (adv),
      .active_i   (rd_active),
      .sck_rise_i (sck_rise),
      .sck_fall_i (sck_fall),
      .bit_i      (bit_idx),
      .dat_o      (tw_dat_o),
      .oe_o       (tw_dat_oe_o)
   );
endmodule

// File: rtl/tw3_slave_chk.sv
module tw3_slave_chk #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic tw_en_i,
   input logic tw_dat_oe_o,
   input logic reg_rd_o,
   input logic reg_wr_o
);
   localparam int unsigned LIM = SYNC_STAGES + 3;

   logic [7:0] low_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
      end else if (tw_en_i) begin
         low_cnt_q <= '0;
      end else if (low_cnt_q < 8'(LIM)) begin
         low_cnt_q <= low_cnt_q + 8'd1;
      end
   end

   // R12
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd_o && reg_wr_o));

   // R12
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> !reg_wr_o);

   // R12
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> !reg_rd_o);

   // R2
   en_low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cnt_q >= 8'(LIM)) |-> !tw_dat_oe_o);

   // R2
   en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cnt_q >= 8'(LIM)) |-> (!reg_rd_o && !reg_wr_o));
endmodule

bind tw3_slave tw3_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .tw_en_i     (tw_en_i),
   .tw_dat_oe_o (tw_dat_oe_o),
   .reg_rd_o    (reg_rd_o),
   .reg_wr_o    (reg_wr_o)
);

// File: tb/tw3_slave_tb_top.sv
module tw3_slave_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       sck = 1'b0;
   logic       dat = 1'b0;
   logic       dat_o;
   logic       oe;
   logic       rd;
   logic       wr;
   logic       ram;
   logic [4:0] addr;
   logic [7:0] wdata;
   logic [7:0] rdata = 8'h00;

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int en_low_clks = 0;
   bit done = 1'b0;

   logic [7:0]  bank [2][32];
   logic [7:0]  exp_mem [2][32];
   logic [13:0] wr_log [$];
   logic [13:0] exp_wr [$];

   always #5 clk = ~clk;

   tw3_slave dut_i (
      .clk(clk), .rst_n(rst_n), .tw_en_i(en), .tw_sck_i(sck), .tw_dat_i(dat),
      .tw_dat_o(dat_o), .tw_dat_oe_o(oe), .reg_rd_o(rd), .reg_wr_o(wr),
      .reg_ram_o(ram), .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // register bank stand-in: data returned one clock after the read strobe
   always @(posedge clk) begin
      if (rst_n) begin
         if (wr) begin
            bank[ram][addr] <= wdata;
            wr_log.push_back({ram, addr, wdata});
         end
         if (rd) begin
            rdata  <= bank[ram][addr];
            rd_cnt <= rd_cnt + 1;
         end
         en_low_clks <= en ? 0 : en_low_clks + 1;
      end
   end

   // per-clock comparison against the reference expectations
   always @(negedge clk) begin
      if (rst_n) begin
         chk(!(rd && wr), "R12 strobe overlap", {rd, wr}, 0);
         if (en_low_clks > 6) begin
            chk(!oe && !rd && !wr, "R2 quiet with enable low", {oe, rd, wr}, 0);
         end
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_xfer();
      en = 1'b1;
      wait_n(8);
   endtask

   task automatic stop_xfer();
      sck = 1'b0;
      dat = 1'b0;
      en  = 1'b0;
      wait_n(16);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         dat = b[i];
         wait_n(8);
         sck = 1'b1;
         wait_n(8);
         sck = 1'b0;
      end
   endtask

   task automatic recv_byte(input bit drive_exp, input logic [7:0] expv, input string req);
      logic [7:0] got;
      got = '0;
      for (int i = 0; i < 8; i++) begin
         wait_n(6);
         chk(oe == drive_exp, {req, " R9 output enable in low half"}, oe, drive_exp);
         got[i] = dat_o;
         sck = 1'b1;
         wait_n(6);
         chk(!oe, "R9 released after rising edge", oe, 0);
         wait_n(2);
         sck = 1'b0;
      end
      if (drive_exp) chk(got == expv, req, got, expv);
   endtask

   task automatic expect_wr(input bit sp, input logic [4:0] a, input logic [7:0] d);
      exp_wr.push_back({sp, a, d});
      exp_mem[sp][a] = d;
   endtask

   task automatic check_writes(input string req);
      chk(wr_log.size() == exp_wr.size(), {req, " write count"}, wr_log.size(), exp_wr.size());
      for (int i = 0; i < exp_wr.size() && i < wr_log.size(); i++) begin
         chk(wr_log[i] == exp_wr[i], req, wr_log[i], exp_wr[i]);
      end
      wr_log.delete();
      exp_wr.delete();
   endtask

   initial begin
      int rd_base;
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 32; a++) begin
            bank[s][a]    = 8'h00;
            exp_mem[s][a] = 8'h00;
         end
      end
      wait_n(4);
      chk(!oe && !rd && !wr, "R9 reset state", {oe, rd, wr}, 0);
      rst_n = 1'b1;
      wait_n(4);

      // R3 R5: single write, clock space, address 5 (cmd 1_0_00101_0)
      start_xfer();
      send_byte(8'h8A);
      send_byte(8'hA5);
      expect_wr(1'b0, 5'd5, 8'hA5);
      stop_xfer();
      check_writes("R5 single write");

      // R6: extra clocks after a single write byte are ignored
      start_xfer();
      send_byte(8'h8C);
      send_byte(8'h3C);
      send_byte(8'hFF);
      expect_wr(1'b0, 5'd6, 8'h3C);
      stop_xfer();
      check_writes("R6 extra clocks ignored");

      // R4: bit 7 clear disables the write
      start_xfer();
      send_byte(8'h0E);
      send_byte(8'h55);
      stop_xfer();
      check_writes("R4 write disabled");

      // R7 R8: single read of address 5, retransmitted
      rd_base = rd_cnt;
      start_xfer();
      send_byte(8'h8B);
      recv_byte(1'b1, exp_mem[0][5], "R7 single read");
      recv_byte(1'b1, exp_mem[0][5], "R8 retransmit 1");
      recv_byte(1'b1, exp_mem[0][5], "R8 retransmit 2");
      stop_xfer();
      chk(rd_cnt - rd_base == 1, "R8 one read strobe", rd_cnt - rd_base, 1);

      // R2: enable dropped in the middle of a read byte
      start_xfer();
      send_byte(8'h8D);
      for (int i = 0; i < 3; i++) begin
         wait_n(8);
         sck = 1'b1;
         wait_n(8);
         sck = 1'b0;
      end
      wait_n(2);
      en = 1'b0;
      wait_n(6);
      chk(!oe, "R2 released after enable low", oe, 0);
      stop_xfer();

      // R1: enable rising while serial clock high -> whole transfer ignored
      sck = 1'b1;
      wait_n(4);
      en = 1'b1;
      wait_n(8);
      sck = 1'b0;
      wait_n(8);
      send_byte(8'h8A);
      send_byte(8'h11);
      stop_xfer();
      check_writes("R1 bad start ignored");
      start_xfer();
      send_byte(8'h8B);
      recv_byte(1'b1, 8'hA5, "R1 address 5 unchanged");
      stop_xfer();

      // R10: burst write to RAM (cmd 1_1_11111_0), 32 bytes, last one dropped
      start_xfer();
      send_byte(8'hFE);
      for (int i = 0; i < 32; i++) begin
         send_byte(8'(i * 7 + 3));
         if (i < 31) expect_wr(1'b1, 5'(i), 8'(i * 7 + 3));
      end
      stop_xfer();
      check_writes("R10 burst write");

      // R11: burst read of RAM, 31 driven bytes then a released byte
      rd_base = rd_cnt;
      start_xfer();
      send_byte(8'hFF);
      for (int i = 0; i < 31; i++) begin
         recv_byte(1'b1, exp_mem[1][i], "R11 burst read byte");
      end
      recv_byte(1'b0, 8'h00, "R11 past burst limit");
      stop_xfer();
      chk(rd_cnt - rd_base == 31, "R11 burst read strobes", rd_cnt - rd_base, 31);

      // R3: space bit separates RAM address 5 from clock address 5
      start_xfer();
      send_byte(8'h8B);
      recv_byte(1'b1, exp_mem[0][5], "R3 clock space read");
      stop_xfer();
      start_xfer();
      send_byte(8'hCB);
      recv_byte(1'b1, exp_mem[1][5], "R3 RAM space read");
      stop_xfer();

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before completion");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule